// File: doc/BRIEF.md
# Transfer Descriptor Queue

This block keeps two queues of block-transfer requests, one for card reads (receive) and one for card writes (transmit). Software adds a request by writing two 32-bit words to the same port address: first the memory buffer address, then the card block address. The request enters its queue only when the second word arrives. Each request moves exactly one 512-byte block.

Software reads the number of free slots in both queues from one status word. Before each push it checks that the count for the target queue is not zero. The block passes requests to a data-transfer engine over a valid/ready handshake, in the order they arrived across both queues. Only one transfer is outstanding at a time. The engine returns one result code per request. The block ORs that code into a data interrupt status register, which software clears by writing zero. A clean transfer reads as bit 0 alone.

A soft reset input empties both queues, drops any half-written request, forgets the outstanding transfer and clears the status register.

Top module: `bdq_top`

## Requirements
- R1: After reset, both free counts equal the queue depth (8), the data status reads 0 and `xfer_valid` is low.
- R2: A request is committed only by the second write to a port. After the first write the free count is unchanged. After the second write it drops by one.
- R3: Writes to offset 0x60 fill the receive queue and writes to 0x80 fill the transmit queue. Reading offset 0x50 returns transmit free slots in bits [7:0] and receive free slots in bits [15:8], with zeros above. Other offsets read zero.
- R4: A write to a port whose free count is zero is dropped and leaves no trace in the queue contents.
- R5: The engine sees the head request as `xfer_buf` (first word), `xfer_blk` (second word) and `xfer_tx` (1 = transmit queue). The queue's free count rises by one on the cycle after the handshake.
- R6: Requests are handed out in their order of commit across both queues.
- R7: `xfer_valid` is high exactly when no transfer is outstanding and some request is queued. After a handshake it stays low until `res_valid` is seen.
- R8: Reading offset 0x54 returns the data status. On each result, `res_code` bits 0 (done), 1 (retry error), 2 (FIFO error), 4 (command error) and 5 (transmission error) are ORed in. Bit 3 and all higher bits read zero.
- R9: Writing zero to 0x54 clears the status. A result in the same cycle still sets its bits. A nonzero write has no effect.
- R10: While `soft_rst` is high at a clock edge, both queues empty, half-written requests are dropped, the outstanding transfer is forgotten and the status is cleared.
- R11: While `xfer_valid` is high and `xfer_ready` is low, the offered request stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of queues and status |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xfer_valid | output | 1 | A request is offered to the engine |
| xfer_ready | input | 1 | Engine accepts the offered request |
| xfer_tx | output | 1 | Offered request direction, 1 = transmit |
| xfer_buf | output | 32 | Memory buffer address of offered request |
| xfer_blk | output | 32 | Card block address of offered request |
| res_valid | input | 1 | Engine reports a result this cycle |
| res_code | input | 6 | Result bits for the finished request |

## Verification
The checker asserts on every cycle that nothing is offered while a transfer is outstanding, and that an offer stays stable under backpressure. It also checks that full-queue writes leave the free count at zero, that a handshake returns a slot, and the effects of a status clear and of a soft reset. Only the bench's scenarios can show end-to-end behaviour: that queued addresses reach the engine intact, that half-written requests stay invisible, and that order is kept across both queues. Its reference model also covers how random result codes combine in the status word, including the masked bit 3.

// File: rtl/bdq_pkg.sv
package bdq_pkg;
    localparam int DW = 32;
    localparam int RES_W = 6;

    localparam logic [7:0] OFS_FREE  = 8'h50;
    localparam logic [7:0] OFS_DSTAT = 8'h54;
    localparam logic [7:0] OFS_RXQ   = 8'h60;
    localparam logic [7:0] OFS_TXQ   = 8'h80;

    // implemented status bits: done, retry, fifo, command, transmission
    localparam logic [RES_W-1:0] STAT_MASK = 6'b11_0111;

    localparam int BLOCK_BYTES = 512;
endpackage

// File: rtl/bdq_fifo.sv
module bdq_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (push) s_d.wp = nxt(s_q.wp);
            if (pop)  s_d.rp = nxt(s_q.rp);
            s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[s_q.wp] <= din;
    end

    assign dout  = mem[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
endmodule

// File: rtl/bdq_asm.sv
module bdq_asm #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    output logic            commit,
    output logic [2*DW-1:0] desc
);
    typedef struct packed {
        logic          half;
        logic [DW-1:0] hold;
    } asm_st_t;

    asm_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (wr) begin
            if (s_q.half) begin
                s_d.half = 1'b0;
            end else begin
                s_d.half = 1'b1;
                s_d.hold = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign commit = wr && s_q.half && !clr;
    assign desc   = {s_q.hold, wdata};
endmodule

// File: rtl/bdq_top.sv
module bdq_top
    import bdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic              xfer_tx,
    output logic [DW-1:0]     xfer_buf,
    output logic [DW-1:0]     xfer_blk,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_code
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int QW = 2 * DW;

    typedef struct packed {
        logic             busy;
        logic [RES_W-1:0] stat;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [CW-1:0] tx_cnt, rx_cnt, tx_free, rx_free;
    logic [$clog2(2*DEPTH+1)-1:0] ord_cnt;
    logic          tx_wr, rx_wr, tx_commit, rx_commit;
    logic [QW-1:0] tx_in, rx_in, tx_head, rx_head;
    logic          tx_empty, rx_empty, ord_empty, head_tx;
    logic          accept, clr_wr;
    logic [RES_W-1:0] dstat;

    assign tx_free = CW'(DEPTH) - tx_cnt;
    assign rx_free = CW'(DEPTH) - rx_cnt;

    assign tx_wr  = reg_wr && !soft_rst && (reg_addr == AW'(OFS_TXQ)) && (tx_free != '0);
    assign rx_wr  = reg_wr && !soft_rst && (reg_addr == AW'(OFS_RXQ)) && (rx_free != '0);
    assign clr_wr = reg_wr && (reg_addr == AW'(OFS_DSTAT)) && (reg_wdata == '0);

    // one assembler and one descriptor queue per direction
    for (genvar g = 0; g < 2; g++) begin : g_dir
        logic          wr_g, commit_g, pop_g, empty_g;
        logic [QW-1:0] desc_g, head_g;
        logic [CW-1:0] cnt_g;

        assign wr_g  = (g == 1) ? tx_wr : rx_wr;
        assign pop_g = accept && (head_tx == (g == 1));

        bdq_asm #(.DW(DW)) u_asm (
            .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr(wr_g),
            .wdata(reg_wdata), .commit(commit_g), .desc(desc_g)
        );

        bdq_fifo #(.W(QW), .DEPTH(DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(commit_g),
            .din(desc_g), .pop(pop_g), .dout(head_g), .empty(empty_g),
            .count(cnt_g)
        );
    end

    assign tx_commit = g_dir[1].commit_g;
    assign rx_commit = g_dir[0].commit_g;
    assign tx_in     = g_dir[1].desc_g;
    assign rx_in     = g_dir[0].desc_g;
    assign tx_head   = g_dir[1].head_g;
    assign rx_head   = g_dir[0].head_g;
    assign tx_empty  = g_dir[1].empty_g;
    assign rx_empty  = g_dir[0].empty_g;
    assign tx_cnt    = g_dir[1].cnt_g;
    assign rx_cnt    = g_dir[0].cnt_g;

    // arrival order across both queues: 1 = transmit
    bdq_fifo #(.W(1), .DEPTH(2*DEPTH)) u_order (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(tx_commit || rx_commit), .din(tx_commit),
        .pop(accept), .dout(head_tx), .empty(ord_empty), .count(ord_cnt)
    );

    assign xfer_valid = !s_q.busy && !ord_empty;
    assign accept     = xfer_valid && xfer_ready;
    assign xfer_tx    = head_tx;
    assign xfer_buf   = head_tx ? tx_head[QW-1:DW] : rx_head[QW-1:DW];
    assign xfer_blk   = head_tx ? tx_head[DW-1:0]  : rx_head[DW-1:0];

    always_comb begin
        s_d = s_q;
        if (soft_rst) begin
            s_d = '0;
        end else begin
            if (accept)         s_d.busy = 1'b1;
            else if (res_valid) s_d.busy = 1'b0;
            s_d.stat = (clr_wr ? '0 : s_q.stat)
                     | (res_valid ? (res_code & STAT_MASK) : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dstat = s_q.stat;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_FREE)) begin
            reg_rdata[7:0]  = 8'(tx_free);
            reg_rdata[15:8] = 8'(rx_free);
        end else if (reg_addr == AW'(OFS_DSTAT)) begin
            reg_rdata[RES_W-1:0] = dstat;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{tx_empty, rx_empty, tx_in, rx_in, ord_cnt};
endmodule

// File: rtl/bdq_chk.sv
module bdq_chk
    import bdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        soft_rst,
    input logic                        reg_wr,
    input logic [AW-1:0]               reg_addr,
    input logic [DW-1:0]               reg_wdata,
    input logic                        xfer_valid,
    input logic                        xfer_ready,
    input logic                        xfer_tx,
    input logic [DW-1:0]               xfer_buf,
    input logic [DW-1:0]               xfer_blk,
    input logic                        res_valid,
    input logic [$clog2(DEPTH+1)-1:0]  tx_free,
    input logic [$clog2(DEPTH+1)-1:0]  rx_free,
    input logic                        tx_commit,
    input logic [RES_W-1:0]            dstat
);
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ready) |=> !xfer_valid); // R7

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready && !soft_rst)
        |=> (xfer_valid && $stable(xfer_tx) && $stable(xfer_buf) && $stable(xfer_blk))); // R11

    AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(OFS_TXQ) && tx_free == '0
         && !(xfer_valid && xfer_ready && xfer_tx) && !soft_rst)
        |=> tx_free == '0); // R4

    AST_FREE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ready && xfer_tx && !tx_commit && !soft_rst)
        |=> tx_free == $past(tx_free) + 1'b1); // R5

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(OFS_DSTAT) && reg_wdata == '0 && !res_valid)
        |=> dstat == '0); // R9

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_free == DEPTH && rx_free == DEPTH && dstat == '0 && !xfer_valid)); // R10

    AST_NO_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !dstat[3]); // R8
endmodule

bind bdq_top bdq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_tx(xfer_tx), .xfer_buf(xfer_buf),
    .xfer_blk(xfer_blk), .res_valid(res_valid), .tx_free(tx_free),
    .rx_free(rx_free), .tx_commit(tx_commit), .dstat(dstat)
);

// File: tb/tb_bdq_top.sv
module tb_bdq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_valid, xfer_tx;
    logic        xfer_ready = 1'b0;
    logic [31:0] xfer_buf, xfer_blk;
    logic        res_valid = 1'b0;
    logic [5:0]  res_code = '0;

    always #2 clk = ~clk;

    bdq_top dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx),
        .xfer_buf(xfer_buf), .xfer_blk(xfer_blk), .res_valid(res_valid),
        .res_code(res_code)
    );

    typedef struct packed { bit tx; logic [31:0] b; logic [31:0] k; } d_t;
    d_t q[$];
    int nchk = 0, nfail = 0;
    int txf = 8, rxf = 8;
    logic [5:0] stat = '0;
    bit busy = 0, half_tx = 0, half_rx = 0;
    logic [31:0] hold_tx = '0, hold_rx = '0;
    int tmr = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h50) return {16'h0, 8'(rxf), 8'(txf)};
        if (a == 8'h54) return {26'h0, stat};
        return '0;
    endfunction

    // one clock of stimulus, checks and reference model
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit rdy, input bit srst, input string tag);
        bit hs;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; xfer_ready = rdy; soft_rst = srst;
        res_valid = 1'b0; res_code = '0;
        if (busy && !srst) begin
            if (tmr == 0) begin res_valid = 1'b1; res_code = 6'($urandom); end
            else tmr--;
        end
        #1;
        chk(xfer_valid === (!busy && q.size() > 0), "R7", 32'(xfer_valid), 32'(!busy && q.size() > 0));
        if (!wr) chk(reg_rdata === exp_read(a), tag, reg_rdata, exp_read(a));
        hs = xfer_valid && rdy && !srst;
        if (hs && q.size() > 0) begin
            chk(xfer_tx === q[0].tx, "R6", 32'(xfer_tx), 32'(q[0].tx));
            chk(xfer_buf === q[0].b, "R5", xfer_buf, q[0].b);
            chk(xfer_blk === q[0].k, "R5", xfer_blk, q[0].k);
        end
        if (srst) begin
            q.delete(); txf = 8; rxf = 8; stat = '0; busy = 0;
            half_tx = 0; half_rx = 0; tmr = 0;
        end else begin
            if (res_valid) begin
                stat = ((wr && a == 8'h54 && d == 0) ? 6'h0 : stat) | (res_code & 6'h37);
                busy = 0;
            end else if (wr && a == 8'h54 && d == 0) stat = '0;
            if (wr && a == 8'h80 && txf > 0) begin
                if (half_tx) begin q.push_back('{1'b1, hold_tx, d}); txf--; half_tx = 0; end
                else begin hold_tx = d; half_tx = 1; end
            end
            if (wr && a == 8'h60 && rxf > 0) begin
                if (half_rx) begin q.push_back('{1'b0, hold_rx, d}); rxf--; half_rx = 0; end
                else begin hold_rx = d; half_rx = 1; end
            end
            if (hs && q.size() > 0) begin
                if (q[0].tx) txf++; else rxf++;
                void'(q.pop_front());
                busy = 1; tmr = $urandom % 4;
            end
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic wrq(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, tag);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 200 && (q.size() > 0 || busy); i++)
            step(1'b0, 8'h50, '0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL R7 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        rd(8'h50, "R1"); rd(8'h54, "R1"); rd(8'h44, "R3");
        // R2: one write does not commit, second one does
        wrq(8'h80, 32'h1000_0000, "R2"); rd(8'h50, "R2");
        wrq(8'h80, 32'h0000_0007, "R2"); rd(8'h50, "R2");
        wrq(8'h60, 32'h2000_0000, "R3"); wrq(8'h60, 32'h0000_0009, "R3"); rd(8'h50, "R3");
        drain("R5"); rd(8'h50, "R5");
        // R4: overfill the transmit queue
        for (int i = 0; i < 10; i++) begin
            wrq(8'h80, 32'hA000_0000 + i, "R4"); wrq(8'h80, 32'h100 + i, "R4");
        end
        rd(8'h50, "R4");
        drain("R4"); rd(8'h50, "R4");
        // R6: interleaved arrival
        for (int i = 0; i < 6; i++) begin
            wrq((i % 3 == 1) ? 8'h80 : 8'h60, 32'hB000_0000 + i, "R6");
            wrq((i % 3 == 1) ? 8'h80 : 8'h60, 32'h200 + i, "R6");
        end
        drain("R6"); rd(8'h54, "R8");
        // R9: nonzero write ignored, zero clears
        wrq(8'h54, 32'h3F, "R9"); rd(8'h54, "R9");
        wrq(8'h54, 32'h0, "R9"); rd(8'h54, "R9");
        // R10: soft reset with half write, queued entries and one in flight
        wrq(8'h60, 32'h1, "R10"); wrq(8'h60, 32'h2, "R10");
        wrq(8'h80, 32'h3, "R10"); wrq(8'h80, 32'h4, "R10"); wrq(8'h80, 32'h5, "R10");
        step(1'b0, 8'h50, '0, 1'b1, 1'b0, "R10");
        step(1'b0, 8'h50, '0, 1'b0, 1'b1, "R10");
        rd(8'h50, "R10"); rd(8'h54, "R10");
        wrq(8'h80, 32'hC0, "R10"); wrq(8'h80, 32'hC1, "R10"); drain("R10");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 10;
            if (r < 3)      step(1'b1, 8'h80, $urandom, ($urandom % 3) != 0, 1'b0, "R2");
            else if (r < 6) step(1'b1, 8'h60, $urandom, ($urandom % 3) != 0, 1'b0, "R2");
            else if (r < 7) step(1'b1, 8'h54, (($urandom % 2) != 0) ? 32'h0 : 32'h5, ($urandom % 2) != 0, 1'b0, "R9");
            else if (r < 8) step(1'b0, 8'h54, '0, ($urandom % 2) != 0, 1'b0, "R8");
            else            step(1'b0, 8'h50, '0, ($urandom % 2) != 0, (i % 997) == 500, "R3");
        end
        drain("R6");
        rd(8'h50, "R5");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule